// File: doc/BRIEF.md
# Bypass Watchdog Mode Controller

This block sits beside a pair of network ports and decides, every clock, which of three states the port pair is in: normal (each port talks to its own host interface), bypass (the two network ports are crossed to each other and the host side is left open), or disconnect (the transmit paths are cut so the far end sees no link). It drives the crossover relay control, the transmit-cut switch control and a bypass indicator lamp. It also reports the state, a watchdog-expired flag and a sticky flag set when a disabled state was refused.

Software reaches the block through a small write port. Through it, software sets the watchdog exponent p, enables the watchdog and forces a base mode. It also writes a capability and default byte. That byte holds two capability-disable bits, the power-up mode, the power-off mode and the failsafe mode. The byte is loaded at reset from a retained input that models non-volatile storage, and it is always presented on an output so that storage can keep it across power cycles. A clock prescaler makes a watchdog tick every `TICK_CYCLES` clocks; with the default of 5,000,000 clocks at 50 MHz this is 100 ms. A timeout is 2^p ticks, which gives 0.1 s up to 3,276.8 s.

When the host stops kicking the watchdog, reports a hang, or power fails, the block moves to the configured failsafe state or power-off state. The capability-disable bits override any request for the state they disable.

Top module: `bwd_ctrl`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) loads the capability byte from nv_cfg_i. It clears the watchdog (p=0, disabled, not expired) and the blocked flag, and sets the base mode to the power-up field. The state after the first edge in reset is that power-up mode, passed through the capability gate of R8.
- R2: When the watchdog is enabled, wdt_expired_o rises exactly 2^p × TICK_CYCLES clock edges after the edge that last reloaded it. On that same edge the state becomes the failsafe mode, unless power fail applies.
- R3: The watchdog is reloaded and its expired flag cleared by any of these: kick_i high at an edge, a write to address 0, or a write to address 2. Kicking more often than the timeout keeps wdt_expired_o low.
- R4: A write to address 0 sets p from wr_data[3:0] and the enable from wr_data[4]. While the enable is 0, wdt_expired_o stays 0.
- R5: While power_fail_i is high, the state is the power-off mode: bypass if capability bit 4 is 1, normal if it is 0. This has top priority over watchdog expiry, host hang and the base mode.
- R6: Without power fail, host_hang_i high or an expired watchdog selects the failsafe mode held in capability bits [6:5].
- R7: A write to address 2 sets the base mode to wr_data[1:0]. This base mode applies on the same edge whenever no power-fail or failsafe condition is active.
- R8: With capability bit 0 set, the state is never bypass; with capability bit 1 set, it is never disconnect. A refused request yields normal and sets blocked_o, which stays set until reset.
- R9: Mode encoding is 00 normal, 01 bypass, 10 disconnect. Code 11 is treated as normal and does not set blocked_o. port_cross_o and bypass_led_o are high only in bypass, and tx_cut_o is high only in disconnect.
- R10: A write to address 1 replaces the capability byte with wr_data. The new byte applies on the same edge and appears on cap_cfg_o. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 watchdog control, 1 capability byte, 2 base mode |
| wr_data | input | 8 | Write data |
| kick_i | input | 1 | Watchdog refresh |
| host_hang_i | input | 1 | Host hang indication |
| power_fail_i | input | 1 | Power failure indication |
| nv_cfg_i | input | 8 | Retained capability byte, loaded at reset |
| port_cross_o | output | 1 | Crossover relay control (bypass) |
| tx_cut_o | output | 1 | Transmit cut switch control (disconnect) |
| bypass_led_o | output | 1 | Bypass indicator |
| mode_o | output | 2 | Current state |
| wdt_expired_o | output | 1 | Watchdog has expired |
| blocked_o | output | 1 | Sticky: a disabled state was refused |
| cap_cfg_o | output | 8 | Current capability byte, for retention |

## Verification
Every mode, flag and capability result is registered once. It is therefore due right after the clock edge that samples the write, kick, hang or power-fail input that causes it, and the bench samples 1 ns after that edge. Watchdog expiry is due exactly 2^p × TICK_CYCLES edges after the reloading edge. The bench counts edges from the reload: it checks the flag still low one edge early, then high on the due edge, for p=2 and for the p=0 boundary.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    localparam logic [1:0] MODE_NORMAL = 2'b00;
    localparam logic [1:0] MODE_BYPASS = 2'b01;
    localparam logic [1:0] MODE_DISC   = 2'b10;

    typedef struct packed {
        logic       spare;
        logic [1:0] failsafe;
        logic       pwroff_byp;
        logic [1:0] pwrup;
        logic       disc_dis;
        logic       byp_dis;
    } cap_t;

    // returns {refused, granted_mode}
    function automatic logic [2:0] gate_mode(logic [1:0] req, cap_t cap);
        logic [2:0] r;
        case (req)
            MODE_BYPASS: r = cap.byp_dis  ? {1'b1, MODE_NORMAL} : {1'b0, MODE_BYPASS};
            MODE_DISC:   r = cap.disc_dis ? {1'b1, MODE_NORMAL} : {1'b0, MODE_DISC};
            default:     r = {1'b0, MODE_NORMAL};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bwd_tick.sv
module bwd_tick #(
    parameter int TICK_CYCLES = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_CYCLES - 1);

    logic [PRE_W-1:0] pre_d, pre_q;

    assign tick_o = run_i && (pre_q == LAST);

    always_comb begin
        pre_d = pre_q + 1'b1;
        if (!rst_n || !run_i || tick_o) begin
            pre_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        pre_q <= pre_d;
    end

    p_pre_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= LAST);

endmodule

// File: rtl/bwd_wdog.sv
module bwd_wdog #(
    parameter int TICK_CYCLES = 5_000_000,
    parameter int P_W         = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic [P_W-1:0] exp_i,
    input  logic           reload_i,
    output logic           expired_d_o,
    output logic           expired_o
);
    localparam int CNT_W = (1 << P_W) + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             expired;
    } wd_t;

    wd_t w_d, w_q;
    logic tick, run, hit;
    logic [CNT_W-1:0] lim_m1;

    assign run    = en_i && !reload_i && !w_q.expired;
    assign lim_m1 = (CNT_W'(1) << exp_i) - 1'b1;
    assign hit    = tick && (w_q.cnt == lim_m1);

    bwd_tick #(.TICK_CYCLES(TICK_CYCLES)) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    always_comb begin
        w_d = w_q;
        if (!rst_n || reload_i || !en_i) begin
            w_d.cnt     = '0;
            w_d.expired = 1'b0;
        end else if (tick) begin
            w_d.cnt     = hit ? '0 : w_q.cnt + 1'b1;
            w_d.expired = w_q.expired | hit;
        end
    end

    always_ff @(posedge clk) begin
        w_q <= w_d;
    end

    assign expired_d_o = w_d.expired;
    assign expired_o   = w_q.expired;

    p_reload_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (!w_q.expired && w_q.cnt == '0));

    p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !w_q.expired);

    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.cnt <= lim_m1);

endmodule

// File: rtl/bwd_mode.sv
module bwd_mode
    import bwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pfail_i,
    input  logic       hang_i,
    input  logic       expired_i,
    input  logic [1:0] base_i,
    input  cap_t       cap_i,
    output logic [1:0] mode_o,
    output logic       blocked_o
);
    typedef struct packed {
        logic [1:0] mode;
        logic       blocked;
    } st_t;

    st_t s_d, s_q;
    logic [1:0] req;
    logic [2:0] gated;

    always_comb begin
        if (!rst_n) begin
            req = cap_i.pwrup;
        end else if (pfail_i) begin
            req = cap_i.pwroff_byp ? MODE_BYPASS : MODE_NORMAL;
        end else if (expired_i || hang_i) begin
            req = cap_i.failsafe;
        end else begin
            req = base_i;
        end
        gated     = gate_mode(req, cap_i);
        s_d.mode    = gated[1:0];
        s_d.blocked = (rst_n ? s_q.blocked : 1'b0) | gated[2];
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign mode_o    = s_q.mode;
    assign blocked_o = s_q.blocked;

    p_blocked_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.blocked |=> s_q.blocked);

    p_mode_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.mode != 2'b11);

endmodule

// File: rtl/bwd_ctrl.sv
module bwd_ctrl
    import bwd_pkg::*;
#(
    parameter int TICK_CYCLES = 5_000_000,
    parameter int P_W         = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       kick_i,
    input  logic       host_hang_i,
    input  logic       power_fail_i,
    input  logic [7:0] nv_cfg_i,
    output logic       port_cross_o,
    output logic       tx_cut_o,
    output logic       bypass_led_o,
    output logic [1:0] mode_o,
    output logic       wdt_expired_o,
    output logic       blocked_o,
    output logic [7:0] cap_cfg_o
);
    localparam logic [1:0] A_WDT  = 2'd0;
    localparam logic [1:0] A_CAP  = 2'd1;
    localparam logic [1:0] A_BASE = 2'd2;

    typedef struct packed {
        logic [P_W-1:0] p;
        logic           en;
        cap_t           cap;
        logic [1:0]     base;
    } regs_t;

    regs_t r_d, r_q;
    logic  reload, exp_d;

    always_comb begin
        r_d = r_q;
        if (!rst_n) begin
            r_d.p    = '0;
            r_d.en   = 1'b0;
            r_d.cap  = cap_t'(nv_cfg_i);
            r_d.base = nv_cfg_i[3:2];
        end else if (wr_en) begin
            case (wr_addr)
                A_WDT: begin
                    r_d.p  = wr_data[P_W-1:0];
                    r_d.en = wr_data[P_W];
                end
                A_CAP:   r_d.cap  = cap_t'(wr_data);
                A_BASE:  r_d.base = wr_data[1:0];
                default: ;
            endcase
        end
        reload = kick_i || (wr_en && (wr_addr == A_WDT || wr_addr == A_BASE));
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    bwd_wdog #(.TICK_CYCLES(TICK_CYCLES), .P_W(P_W)) i_wdog (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (r_q.en),
        .exp_i       (r_q.p),
        .reload_i    (reload),
        .expired_d_o (exp_d),
        .expired_o   (wdt_expired_o)
    );

    bwd_mode i_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .pfail_i   (power_fail_i),
        .hang_i    (host_hang_i),
        .expired_i (exp_d),
        .base_i    (r_d.base),
        .cap_i     (r_d.cap),
        .mode_o    (mode_o),
        .blocked_o (blocked_o)
    );

    assign port_cross_o = (mode_o == MODE_BYPASS);
    assign bypass_led_o = (mode_o == MODE_BYPASS);
    assign tx_cut_o     = (mode_o == MODE_DISC);
    assign cap_cfg_o    = r_q.cap;

    p_no_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cap.byp_dis |-> !port_cross_o);

    p_no_disc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cap.disc_dis |-> !tx_cut_o);

    p_pfail_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (power_fail_i && !wr_en) |=>
            (mode_o == ((r_q.cap.pwroff_byp && !r_q.cap.byp_dis) ? MODE_BYPASS : MODE_NORMAL)));

    p_relays_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_cross_o && tx_cut_o));

endmodule

// File: tb/test_bwd_ctrl.sv
module test_bwd_ctrl;

    localparam int TICK = 4;

    logic       clk = 1'b0;
    logic       rst_n, wr_en, kick_i, host_hang_i, power_fail_i;
    logic [1:0] wr_addr;
    logic [7:0] wr_data, nv_cfg_i;
    logic       port_cross_o, tx_cut_o, bypass_led_o, wdt_expired_o, blocked_o;
    logic [1:0] mode_o;
    logic [7:0] cap_cfg_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bwd_ctrl #(.TICK_CYCLES(TICK), .P_W(4)) i_bwd_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .kick_i(kick_i), .host_hang_i(host_hang_i), .power_fail_i(power_fail_i),
        .nv_cfg_i(nv_cfg_i), .port_cross_o(port_cross_o), .tx_cut_o(tx_cut_o),
        .bypass_led_o(bypass_led_o), .mode_o(mode_o), .wdt_expired_o(wdt_expired_o),
        .blocked_o(blocked_o), .cap_cfg_o(cap_cfg_o)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic do_reset(logic [7:0] nv);
        nv_cfg_i = nv; rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    task automatic chk_mode(string req, logic [1:0] m);
        chk(req, mode_o, m);
        chk(req, port_cross_o, m == 2'b01);
        chk(req, bypass_led_o, m == 2'b01);
        chk(req, tx_cut_o, m == 2'b10);
    endtask

    // {refused, mode} from the requirement text
    function automatic logic [2:0] want(logic [7:0] cap, logic [1:0] base, logic pf, logic hg);
        logic [1:0] rq;
        rq = pf ? (cap[4] ? 2'b01 : 2'b00) : (hg ? cap[6:5] : base);
        if (rq == 2'b01) return cap[0] ? 3'b100 : 3'b001;
        if (rq == 2'b10) return cap[1] ? 3'b100 : 3'b010;
        return 3'b000;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] mcap;
        logic [1:0] mbase;
        logic       mblk;
        logic [2:0] w;
        void'($urandom(32'd1234));
        wr_en = 0; wr_addr = 0; wr_data = 0; kick_i = 0; host_hang_i = 0; power_fail_i = 0;

        // R1 reset: failsafe=bypass, pwroff=bypass, pwrup=bypass, no disables
        do_reset(8'h34);
        chk_mode("R1", 2'b01);
        chk("R1", wdt_expired_o, 0);
        chk("R1", blocked_o, 0);
        chk("R10", cap_cfg_o, 8'h34);

        wr(2'd2, 8'h00);
        chk_mode("R7", 2'b00);

        // R2 expiry: p=2 -> 4 ticks x 4 clocks = 16 edges
        wr(2'd0, 8'h12);
        repeat (15) step();
        chk("R2", wdt_expired_o, 0);
        chk_mode("R2", 2'b00);
        step();
        chk("R2", wdt_expired_o, 1);
        chk_mode("R2", 2'b01);

        kick_i = 1; step(); kick_i = 0;
        chk("R3", wdt_expired_o, 0);
        chk_mode("R3", 2'b00);
        for (int k = 0; k < 6; k++) begin
            repeat (11) step();
            kick_i = 1; step(); kick_i = 0;
            chk("R3", wdt_expired_o, 0);
        end

        // p=0 boundary: one tick = 4 edges
        wr(2'd0, 8'h10);
        repeat (3) step();
        chk("R2", wdt_expired_o, 0);
        step();
        chk("R2", wdt_expired_o, 1);
        wr(2'd3, 8'hFF);
        chk("R10", cap_cfg_o, 8'h34);
        chk_mode("R10", 2'b01);

        wr(2'd0, 8'h00);
        chk("R4", wdt_expired_o, 0);
        chk_mode("R4", 2'b00);
        repeat (100) step();
        chk("R4", wdt_expired_o, 0);

        power_fail_i = 1; step();
        chk_mode("R5", 2'b01);
        wr(2'd2, 8'h02);
        chk_mode("R5", 2'b01);
        power_fail_i = 0; step();
        chk_mode("R7", 2'b10);
        wr(2'd1, 8'h24);
        power_fail_i = 1; step();
        chk_mode("R5", 2'b00);
        power_fail_i = 0;

        wr(2'd2, 8'h00);
        wr(2'd1, 8'h44);
        host_hang_i = 1; step();
        chk_mode("R6", 2'b10);
        host_hang_i = 0; step();
        chk_mode("R6", 2'b00);

        wr(2'd1, 8'h45);
        chk("R10", cap_cfg_o, 8'h45);
        chk("R8", blocked_o, 0);
        wr(2'd2, 8'h01);
        chk_mode("R8", 2'b00);
        chk("R8", blocked_o, 1);
        wr(2'd1, 8'h46);
        wr(2'd2, 8'h00);
        host_hang_i = 1; step();
        chk_mode("R8", 2'b00);
        chk("R8", blocked_o, 1);
        host_hang_i = 0;

        do_reset(8'h00); step();
        wr(2'd2, 8'h03);
        chk_mode("R9", 2'b00);
        chk("R9", blocked_o, 0);

        // R1 with a disabled power-up mode
        do_reset(8'h05); step();
        chk_mode("R1", 2'b00);
        chk("R1", blocked_o, 1);

        // random mix with watchdog disabled
        do_reset(8'h00); step();
        mcap = 8'h00; mbase = 2'b00; mblk = 1'b0;
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 3);
            power_fail_i = ($urandom_range(0, 5) == 0);
            host_hang_i  = ($urandom_range(0, 3) == 0);
            wr_en = 1'b0;
            if (op == 1) begin
                wr_en = 1; wr_addr = 2'd1; wr_data = 8'($urandom);
                mcap = wr_data;
            end else if (op == 2) begin
                wr_en = 1; wr_addr = 2'd2; wr_data = 8'($urandom);
                mbase = wr_data[1:0];
            end
            w = want(mcap, mbase, power_fail_i, host_hang_i);
            mblk = mblk | w[2];
            step();
            wr_en = 1'b0;
            chk_mode("R8", w[1:0]);
            chk("R8", blocked_o, mblk);
            chk("R10", cap_cfg_o, mcap);
            chk("R4", wdt_expired_o, 0);
        end
        power_fail_i = 0; host_hang_i = 0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule